// File: doc/BRIEF.md
# Program Exception Classifier and Encoder

This block sits beside the execution units of a CPU. It gathers the condition flags that those units raise for one instruction and turns them into one interruption code for a program check. The flags cover an opcode that is not implemented, a privileged opcode issued in problem state, an execute-type instruction whose target is another execute instruction, and a set of arithmetic result indicators. The arithmetic indicators are lost significant bits in fixed-point divide or decimal work, and, for floating point, the signed characteristic of the result and whether a fraction is zero.

The flags are sampled in any cycle where `chk_valid` is high. If at least one condition holds, the block picks the one with the highest priority, encodes it, stores the code in a register, and raises `exc_valid`. The code and the strobe then stay unchanged until the consumer pulses `exc_ack`. A controller with two states, `ST_IDLE` and `ST_HOLD`, does the sequencing. Its two transitions are named *capture* (from `ST_IDLE` to `ST_HOLD` when a sampled condition is found) and *release* (from `ST_HOLD` to `ST_IDLE` on acknowledge).

Top module: `prog_exc_encoder`

## Requirements
- R1: After reset, `exc_valid` is 0 and `exc_code` is 0x00.
- R2: When `chk_valid` is high and `op_impl` is 0, the code 0x01 is reported. This condition outranks every other condition.
- R3: A privileged opcode (`op_priv`=1) sampled while `problem_state`=1 reports code 0x02. When `problem_state`=0, the same opcode raises nothing.
- R4: An execute-type instruction whose target is an execute instruction (`exec_of_exec`=1) reports code 0x03.
- R5: Lost bits in a fixed-point divide report 0x09. Lost digits in decimal arithmetic other than divide report 0x0A. Lost digits in a decimal divide report 0x0B.
- R6: With `fp_result`=1, a characteristic above 127 and a nonzero fraction (`fp_frac_zero`=0) report 0x0C. A characteristic of exactly 127, or a zero fraction, does not report 0x0C.
- R7: With `fp_result`=1, a negative characteristic and a nonzero fraction report 0x0D. A characteristic of 0, or a zero fraction, does not report 0x0D.
- R8: A floating add or subtract (`fp_addsub`=1) whose result fraction is zero reports 0x0E.
- R9: A floating divide (`fp_divide`=1) whose divisor fraction is zero (`fp_divisor_zero`=1) reports 0x0F.
- R10: When several conditions hold in the same cycle, exactly one code is reported. The order from highest to lowest priority is 0x01, 0x02, 0x03, then 0x09 through 0x0F in ascending order.
- R11: `exc_valid` rises one cycle after the sampling cycle. It and `exc_code` then stay unchanged until `exc_ack` is sampled high, and `exc_valid` is 0 in the following cycle.
- R12: A sample that carries a condition while `exc_valid` is high is ignored, and `exc_code` keeps the first code.
- R13: A cycle with `chk_valid` low, or with no condition true, leaves `exc_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | The flags in this cycle belong to an instruction and are sampled |
| op_impl | input | 1 | The opcode is implemented and its unit is present |
| op_priv | input | 1 | The opcode is privileged |
| problem_state | input | 1 | The status-word problem-state bit |
| exec_of_exec | input | 1 | The target of an execute-type instruction is itself an execute instruction |
| fxd_div_lost | input | 1 | Fixed-point divide lost significant bits |
| dec_ovf_lost | input | 1 | Decimal arithmetic (not divide) lost significant digits |
| dec_div_lost | input | 1 | Decimal divide lost significant digits |
| fp_result | input | 1 | A floating arithmetic result is present in `fp_char`/`fp_frac_zero` |
| fp_addsub | input | 1 | The floating operation is an add or a subtract |
| fp_divide | input | 1 | The floating operation is a divide |
| fp_char | input | 9 | Signed characteristic of the floating result |
| fp_frac_zero | input | 1 | The result fraction is zero |
| fp_divisor_zero | input | 1 | The divisor fraction is zero |
| exc_ack | input | 1 | The consumer takes the held code |
| exc_valid | output | 1 | A code is held |
| exc_code | output | 8 | The held interruption code |

## Verification
A code is due at the first sample point after the rising edge that closes the `chk_valid` cycle. It is one register deep, so the bench drives inputs on the falling edge and reads `exc_valid` and `exc_code` on the next falling edge. The cleared strobe appears one edge after `exc_ack` is driven, and the bench reads it on the falling edge after that edge. While a code is held, the bench applies a further sample with conditions, then checks at the next falling edge that the code has not changed.

// File: rtl/prog_exc_pkg.sv
package prog_exc_pkg;

    parameter int PE_CODE_W = 8;
    parameter int PE_NCOND  = 10;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } pe_state_e;

    // Condition index -> interruption code; index 0 has the highest priority.
    function automatic logic [PE_CODE_W-1:0] cond_code(input int idx);
        logic [PE_CODE_W-1:0] c;
        case (idx)
            0:       c = PE_CODE_W'(8'h01);
            1:       c = PE_CODE_W'(8'h02);
            2:       c = PE_CODE_W'(8'h03);
            default: c = PE_CODE_W'(idx + 6);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/prog_exc_detect.sv
module prog_exc_detect
    import prog_exc_pkg::*;
#(
    parameter int CHAR_W     = 9,
    parameter int CHAR_LIMIT = 127
) (
    input  logic                     op_impl,
    input  logic                     op_priv,
    input  logic                     problem_state,
    input  logic                     exec_of_exec,
    input  logic                     fxd_div_lost,
    input  logic                     dec_ovf_lost,
    input  logic                     dec_div_lost,
    input  logic                     fp_result,
    input  logic                     fp_addsub,
    input  logic                     fp_divide,
    input  logic signed [CHAR_W-1:0] fp_char,
    input  logic                     fp_frac_zero,
    input  logic                     fp_divisor_zero,
    output logic [PE_NCOND-1:0]      cond
);

    localparam logic signed [CHAR_W-1:0] LIMIT = CHAR_W'(CHAR_LIMIT);

    logic char_high;
    logic char_neg;

    assign char_high = (fp_char > LIMIT);
    assign char_neg  = fp_char[CHAR_W-1];

    always_comb begin
        cond    = '0;
        cond[0] = ~op_impl;
        cond[1] = op_priv & problem_state;
        cond[2] = exec_of_exec;
        cond[3] = fxd_div_lost;
        cond[4] = dec_ovf_lost;
        cond[5] = dec_div_lost;
        cond[6] = fp_result & char_high & ~fp_frac_zero;
        cond[7] = fp_result & char_neg & ~fp_frac_zero;
        cond[8] = fp_addsub & fp_frac_zero;
        cond[9] = fp_divide & fp_divisor_zero;
    end

endmodule

// File: rtl/prog_exc_prio.sv
module prog_exc_prio
    import prog_exc_pkg::*;
(
    input  logic [PE_NCOND-1:0]  cond,
    output logic                 hit,
    output logic [PE_CODE_W-1:0] code
);

    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int i = PE_NCOND - 1; i >= 0; i--) begin
            if (cond[i]) begin
                hit  = 1'b1;
                code = cond_code(i);
            end
        end
    end

endmodule

// File: rtl/prog_exc_ctrl.sv
module prog_exc_ctrl
    import prog_exc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic                 hit,
    input  logic [PE_CODE_W-1:0] code_in,
    input  logic                 ack,
    output logic                 valid,
    output logic [PE_CODE_W-1:0] code_out
);

    pe_state_e state_q;
    pe_state_e state_d;
    logic      capture;

    assign capture = (state_q == ST_IDLE) && sample && hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (capture) state_d = ST_HOLD;
            ST_HOLD: if (ack)     state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_out <= '0;
        else if (capture) code_out <= code_in;
    end

    assign valid = (state_q == ST_HOLD);

endmodule

// File: rtl/prog_exc_encoder.sv
module prog_exc_encoder
    import prog_exc_pkg::*;
#(
    parameter int CHAR_W     = 9,
    parameter int CHAR_LIMIT = 127
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chk_valid,
    input  logic                     op_impl,
    input  logic                     op_priv,
    input  logic                     problem_state,
    input  logic                     exec_of_exec,
    input  logic                     fxd_div_lost,
    input  logic                     dec_ovf_lost,
    input  logic                     dec_div_lost,
    input  logic                     fp_result,
    input  logic                     fp_addsub,
    input  logic                     fp_divide,
    input  logic signed [CHAR_W-1:0] fp_char,
    input  logic                     fp_frac_zero,
    input  logic                     fp_divisor_zero,
    input  logic                     exc_ack,
    output logic                     exc_valid,
    output logic [PE_CODE_W-1:0]     exc_code
);

    logic [PE_NCOND-1:0]  cond;
    logic                 hit;
    logic [PE_CODE_W-1:0] sel_code;

    prog_exc_detect #(
        .CHAR_W     (CHAR_W),
        .CHAR_LIMIT (CHAR_LIMIT)
    ) u_detect (
        .op_impl         (op_impl),
        .op_priv         (op_priv),
        .problem_state   (problem_state),
        .exec_of_exec    (exec_of_exec),
        .fxd_div_lost    (fxd_div_lost),
        .dec_ovf_lost    (dec_ovf_lost),
        .dec_div_lost    (dec_div_lost),
        .fp_result       (fp_result),
        .fp_addsub       (fp_addsub),
        .fp_divide       (fp_divide),
        .fp_char         (fp_char),
        .fp_frac_zero    (fp_frac_zero),
        .fp_divisor_zero (fp_divisor_zero),
        .cond            (cond)
    );

    prog_exc_prio u_prio (
        .cond (cond),
        .hit  (hit),
        .code (sel_code)
    );

    prog_exc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (chk_valid),
        .hit      (hit),
        .code_in  (sel_code),
        .ack      (exc_ack),
        .valid    (exc_valid),
        .code_out (exc_code)
    );

endmodule

// File: rtl/prog_exc_encoder_chk.sv
module prog_exc_encoder_chk
    import prog_exc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chk_valid,
    input logic                 op_impl,
    input logic                 exc_ack,
    input logic                 exc_valid,
    input logic [PE_CODE_W-1:0] exc_code
);

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_ack) |=> (exc_valid && exc_code == $past(exc_code)));

    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_ack) |=> !exc_valid);

    p_rise_needs_sample_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && !chk_valid) |=> !exc_valid);

    p_op_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && chk_valid && !op_impl) |=> (exc_valid && exc_code == 8'h01));

    p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code inside {8'h01, 8'h02, 8'h03, [8'h09:8'h0F]}));

    p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && chk_valid && !exc_ack) |=> $stable(exc_code));

endmodule

bind prog_exc_encoder prog_exc_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .op_impl   (op_impl),
    .exc_ack   (exc_ack),
    .exc_valid (exc_valid),
    .exc_code  (exc_code)
);

// File: tb/prog_exc_encoder_test.sv
`timescale 1ns/1ps
module prog_exc_encoder_test;

    typedef struct packed {
        logic              impl;
        logic              priv;
        logic              prob;
        logic              exx;
        logic              fxd;
        logic              dovf;
        logic              ddiv;
        logic              fres;
        logic              fadd;
        logic              fdiv;
        logic              fzero;
        logic              dzero;
        logic signed [8:0] chr;
    } stim_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_valid = 1'b0;
    logic exc_ack = 1'b0;
    stim_t s_drv;
    logic exc_valid;
    logic [7:0] exc_code;
    int n_tests = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prog_exc_encoder uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .chk_valid       (chk_valid),
        .op_impl         (s_drv.impl),
        .op_priv         (s_drv.priv),
        .problem_state   (s_drv.prob),
        .exec_of_exec    (s_drv.exx),
        .fxd_div_lost    (s_drv.fxd),
        .dec_ovf_lost    (s_drv.dovf),
        .dec_div_lost    (s_drv.ddiv),
        .fp_result       (s_drv.fres),
        .fp_addsub       (s_drv.fadd),
        .fp_divide       (s_drv.fdiv),
        .fp_char         (s_drv.chr),
        .fp_frac_zero    (s_drv.fzero),
        .fp_divisor_zero (s_drv.dzero),
        .exc_ack         (exc_ack),
        .exc_valid       (exc_valid),
        .exc_code        (exc_code)
    );

    function automatic logic [7:0] model(stim_t s);
        if (!s.impl)                                return 8'h01;
        if (s.priv && s.prob)                       return 8'h02;
        if (s.exx)                                  return 8'h03;
        if (s.fxd)                                  return 8'h09;
        if (s.dovf)                                 return 8'h0A;
        if (s.ddiv)                                 return 8'h0B;
        if (s.fres && s.chr > 127 && !s.fzero)      return 8'h0C;
        if (s.fres && s.chr < 0 && !s.fzero)        return 8'h0D;
        if (s.fadd && s.fzero)                      return 8'h0E;
        if (s.fdiv && s.dzero)                      return 8'h0F;
        return 8'h00;
    endfunction

    function automatic stim_t quiet();
        stim_t q = '0;
        q.impl = 1'b1;
        return q;
    endfunction

    function automatic stim_t rnd();
        stim_t r;
        int pick;
        r.impl  = ($urandom % 8) != 0;
        r.priv  = ($urandom % 4) == 0;
        r.prob  = $urandom % 2;
        r.exx   = ($urandom % 6) == 0;
        r.fxd   = ($urandom % 6) == 0;
        r.dovf  = ($urandom % 6) == 0;
        r.ddiv  = ($urandom % 6) == 0;
        r.fres  = $urandom % 2;
        r.fadd  = ($urandom % 3) == 0;
        r.fdiv  = ($urandom % 3) == 0;
        r.fzero = $urandom % 2;
        r.dzero = $urandom % 2;
        pick = $urandom % 8;
        case (pick)
            0: r.chr = -9'sd1;
            1: r.chr = 9'sd0;
            2: r.chr = 9'sd127;
            3: r.chr = 9'sd128;
            4: r.chr = -9'sd256;
            5: r.chr = 9'sd255;
            default: r.chr = 9'($urandom);
        endcase
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Sample one stimulus, check capture, hold under a second sample, then release.
    task automatic run_case(input stim_t s, input string req);
        logic [7:0] exp;
        stim_t other;
        exp = model(s);
        @(negedge clk);
        s_drv = s;
        chk_valid = 1'b1;
        @(negedge clk);
        s_drv = quiet();
        chk_valid = 1'b0;
        if (exp == 8'h00) begin
            check(exc_valid == 1'b0, req, exc_valid, 0);
        end else begin
            check(exc_valid == 1'b1 && exc_code == exp, req, exc_code, exp);
            other = rnd();
            other.impl = 1'b0;
            s_drv = other;
            chk_valid = 1'b1;
            @(negedge clk);
            s_drv = quiet();
            chk_valid = 1'b0;
            check(exc_valid == 1'b1 && exc_code == exp, "R12", exc_code, exp);
            @(negedge clk);
            check(exc_valid == 1'b1 && exc_code == exp, "R11 hold", exc_code, exp);
            exc_ack = 1'b1;
            @(negedge clk);
            exc_ack = 1'b0;
            check(exc_valid == 1'b0, "R11 release", exc_valid, 0);
        end
    endtask

    function automatic string req_of(logic [7:0] c);
        case (c)
            8'h01: return "R2";
            8'h02: return "R3";
            8'h03: return "R4";
            8'h09, 8'h0A, 8'h0B: return "R5";
            8'h0C: return "R6";
            8'h0D: return "R7";
            8'h0E: return "R8";
            8'h0F: return "R9";
            default: return "R13";
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        stim_t s;
        void'($urandom(32'd2024));
        s_drv = quiet();
        #25;
        check(exc_valid == 1'b0 && exc_code == 8'h00, "R1", exc_code, 0);
        rst_n = 1'b1;

        // R13: no sample, and a sample with nothing true
        s = quiet(); s.impl = 1'b0;
        @(negedge clk); s_drv = s; chk_valid = 1'b0;
        @(negedge clk); s_drv = quiet();
        check(exc_valid == 1'b0, "R13 no sample", exc_valid, 0);
        run_case(quiet(), "R13");

        s = quiet(); s.impl = 1'b0;                       run_case(s, "R2");
        s = quiet(); s.priv = 1; s.prob = 1;              run_case(s, "R3");
        s = quiet(); s.priv = 1; s.prob = 0;              run_case(s, "R3 supervisor");
        s = quiet(); s.exx = 1;                           run_case(s, "R4");
        s = quiet(); s.fxd = 1;                           run_case(s, "R5 fxdiv");
        s = quiet(); s.dovf = 1;                          run_case(s, "R5 decovf");
        s = quiet(); s.ddiv = 1;                          run_case(s, "R5 decdiv");
        s = quiet(); s.fres = 1; s.chr = 9'sd128;         run_case(s, "R6");
        s = quiet(); s.fres = 1; s.chr = 9'sd127;         run_case(s, "R6 edge");
        s = quiet(); s.fres = 1; s.chr = 9'sd200; s.fzero = 1; run_case(s, "R6 zero frac");
        s = quiet(); s.fres = 1; s.chr = -9'sd1;          run_case(s, "R7");
        s = quiet(); s.fres = 1; s.chr = 9'sd0;           run_case(s, "R7 edge");
        s = quiet(); s.fres = 1; s.chr = -9'sd40; s.fzero = 1; run_case(s, "R7 zero frac");
        s = quiet(); s.fadd = 1; s.fzero = 1;             run_case(s, "R8");
        s = quiet(); s.fdiv = 1; s.dzero = 1;             run_case(s, "R9");
        s = quiet(); s.fdiv = 1; s.dzero = 0;             run_case(s, "R9 nonzero divisor");

        // R10: stacked conditions
        s = quiet(); s.impl = 0; s.priv = 1; s.prob = 1; s.exx = 1; s.fxd = 1; run_case(s, "R10 op");
        s = quiet(); s.priv = 1; s.prob = 1; s.exx = 1; s.ddiv = 1;           run_case(s, "R10 priv");
        s = quiet(); s.dovf = 1; s.ddiv = 1; s.fdiv = 1; s.dzero = 1;         run_case(s, "R10 dec");
        s = quiet(); s.fres = 1; s.fadd = 1; s.fzero = 1; s.fdiv = 1; s.dzero = 1; s.chr = 9'sd150;
        run_case(s, "R10 fp");

        // R11: ack while idle has no effect on a later capture
        @(negedge clk); exc_ack = 1'b1;
        @(negedge clk); exc_ack = 1'b0;
        check(exc_valid == 1'b0, "R11 idle ack", exc_valid, 0);

        for (int k = 0; k < 300; k++) begin
            s = rnd();
            run_case(s, req_of(model(s)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule